// File: doc/BRIEF.md
# SPI Flash Configuration Registers and Software Reset Sequencer

This block sits behind the command front end of an SPI flash slave. It holds three configuration registers: a 16-bit persistent one (`nv`), an 8-bit volatile one (`v`) and an 8-bit enhanced-volatile one (`ev`). It also holds the write-enable latch, the 4-byte address mode flag and the extended address segment register. The front end hands it each frame's opcode byte and then any following data bytes. For read opcodes the block returns register bytes one per data-byte slot. For write opcodes it collects the bytes and commits them when the last one arrives.

Reset is a two-step sequence. An arming opcode must come first, and the reset opcode must follow as the next opcode. A reset from that sequence, or a hardware reset, rebuilds the volatile register, the enhanced-volatile register, the address mode and the segment register from bits of the persistent register. A software reset also pulses `addr_clr`, so the front end drops its current address and its command state.

The controller is a four-state machine, clocked by `clk`.
- `ST_IDLE` waits for an opcode. It moves to `ST_COLLECT` on a write opcode while write-enable is set. It moves to `ST_READ` on a read opcode. It moves to `ST_DRAIN` on any other opcode, or on a write opcode while write-enable is clear.
- `ST_COLLECT` moves to `ST_DRAIN` once the last data byte is taken.
- `ST_READ` and `ST_DRAIN` hold until the frame ends.
- Every state returns to `ST_IDLE` whenever `cs_n` is high.

Top module: `flash_cfg_ctrl`

## Requirements
- R1: After hardware reset the register values are as follows.
  - `nv` = 0x8FFF, `v` = 0x83, `ev` = 0xDF.
  - `four_byte` = 0, `ext_addr` = 0, `wel` = 0, `rst_armed` = 0.
- R2: Read opcodes return one byte per data-byte slot on `dout`, with `dout_valid` high for one cycle after each slot.
  - 0xB5 returns `nv` low byte, then `nv` high byte.
  - 0x85 returns `v`.
  - 0x65 returns `ev`.
  - Every slot past the register's length returns 0x00.
- R3: Write opcodes change their register only when `wel` was set when the opcode arrived. Otherwise the register is unchanged.
  - 0xB1 writes `nv` from two bytes, low byte first.
  - 0x81 writes `v` from one byte.
  - 0x61 writes `ev` from one byte.
- R4: A write commits only when its final byte arrives while `cs_n` is low. If the frame ends before that byte, or in the same cycle as that byte, the register is unchanged.
- R5: Opcode 0x06 sets `wel`. Opcode 0x04 clears it.
- R6: Opcode 0x66 sets `rst_armed`. Any following opcode other than 0x99 clears it.
- R7: Opcode 0x99 performs a software reset only when `rst_armed` is set. When `rst_armed` is clear, 0x99 changes no register and gives no `addr_clr` pulse.
- R8: A software reset has these effects.
  - `wel` and `rst_armed` are cleared.
  - `addr_clr` is high for exactly one cycle.
  - `nv` keeps its value.
- R9: On any reset, `v` is rebuilt from `nv`.
  - Bits [1:0] are set to 1.
  - Bit 3 is 1 unless `nv`[11:9] = 3'b111.
  - Bits [7:4] take `nv`[15:12].
  - Bit 2 is 0.
- R10: On any reset, `ev` is rebuilt from `nv`.
  - Bits [4:0] = 5'h1F.
  - Bit 5 is 0.
  - Bit 6 takes `nv`[2].
  - Bit 7 takes `nv`[3].
- R11: On any reset, the address state is rebuilt from `nv`.
  - `four_byte` becomes the inverse of `nv`[0].
  - `ext_addr` becomes 3 when `nv`[1] is 0, and 0 otherwise.
  - Apart from resets, opcode 0xB7 sets `four_byte` and opcode 0xE9 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cs_n | input | 1 | Active-low chip select; high ends the frame |
| cmd_valid | input | 1 | Opcode byte present |
| cmd_byte | input | 8 | Opcode byte |
| dat_valid | input | 1 | Data byte slot present |
| dat_byte | input | 8 | Data byte |
| dout_valid | output | 1 | Read-back byte valid |
| dout | output | 8 | Read-back byte |
| wel | output | 1 | Write-enable latch |
| rst_armed | output | 1 | Reset sequence armed |
| four_byte | output | 1 | 4-byte address mode |
| ext_addr | output | EXT_W (8) | Extended address segment |
| vol_cfg | output | 8 | Volatile configuration register |
| evol_cfg | output | 8 | Enhanced-volatile configuration register |
| addr_clr | output | 1 | One-cycle pulse telling the front end to clear its address and command state |

## Verification
Two events can meet in one cycle: the final data byte of a register write, and the deselect that ends the frame. The bench provokes this by raising `cs_n` in the very cycle that carries the last byte of a 0xB1, 0x81 or 0x61 write. It then reads the register back and expects it to be unchanged. A second case cuts a two-byte write after its first byte. Both outcomes are judged against a write that completes, where the register does change.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int NV_W   = 16;

    localparam logic [BYTE_W-1:0] OP_WEL_SET   = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WEL_CLR   = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RST_ARM   = 8'h66;
    localparam logic [BYTE_W-1:0] OP_RST_GO    = 8'h99;
    localparam logic [BYTE_W-1:0] OP_NV_RD     = 8'hB5;
    localparam logic [BYTE_W-1:0] OP_NV_WR     = 8'hB1;
    localparam logic [BYTE_W-1:0] OP_V_RD      = 8'h85;
    localparam logic [BYTE_W-1:0] OP_V_WR      = 8'h81;
    localparam logic [BYTE_W-1:0] OP_EV_RD     = 8'h65;
    localparam logic [BYTE_W-1:0] OP_EV_WR     = 8'h61;
    localparam logic [BYTE_W-1:0] OP_ADDR4_ON  = 8'hB7;
    localparam logic [BYTE_W-1:0] OP_ADDR4_OFF = 8'hE9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_READ,
        ST_DRAIN
    } seq_state_t;

    // Volatile register rebuilt from the persistent one.
    function automatic logic [BYTE_W-1:0] vcfg_from_nv(input logic [NV_W-1:0] nv);
        logic [BYTE_W-1:0] r;
        r      = 8'h03;
        r[3]   = (nv[11:9] != 3'b111);
        r[7:4] = nv[15:12];
        return r;
    endfunction

    // Enhanced-volatile register rebuilt from the persistent one.
    function automatic logic [BYTE_W-1:0] evcfg_from_nv(input logic [NV_W-1:0] nv);
        logic [BYTE_W-1:0] r;
        r    = 8'h1F;
        r[6] = nv[2];
        r[7] = nv[3];
        return r;
    endfunction

endpackage

// File: rtl/flash_rst_arm.sv
module flash_rst_arm
    import flash_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_fire,
    input  logic [BYTE_W-1:0] op_code,
    output logic              armed,
    output logic              sw_reset
);

    logic armed_q;

    // Armed only by the arming opcode. Every other opcode drops it,
    // including the reset opcode, which consumes the armed state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (op_fire)
            armed_q <= (op_code == OP_RST_ARM);
    end

    assign sw_reset = op_fire && (op_code == OP_RST_GO) && armed_q;
    assign armed    = armed_q;

    assert_arm_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && op_code != OP_RST_ARM) |=> !armed_q);

endmodule

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
    import flash_cfg_pkg::*;
#(
    parameter logic [15:0] NV_DEFAULT = 16'h8FFF,
    parameter int          EXT_W      = 8,
    parameter int          UPPER_SEG  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              four_set,
    input  logic              four_clr,
    input  logic              wr_nv,
    input  logic              wr_v,
    input  logic              wr_ev,
    input  logic [NV_W-1:0]   wr_word,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [NV_W-1:0]   nv,
    output logic [BYTE_W-1:0] vcfg,
    output logic [BYTE_W-1:0] evcfg,
    output logic              wel,
    output logic              four_byte,
    output logic [EXT_W-1:0]  ext_addr
);

    localparam logic [EXT_W-1:0] SEG_UPPER = EXT_W'(UPPER_SEG);

    logic [NV_W-1:0]   nv_q;
    logic [BYTE_W-1:0] v_q, ev_q;
    logic              wel_q, four_q;
    logic [EXT_W-1:0]  ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv_q   <= NV_DEFAULT;
            v_q    <= vcfg_from_nv(NV_DEFAULT);
            ev_q   <= evcfg_from_nv(NV_DEFAULT);
            four_q <= ~NV_DEFAULT[0];
            ext_q  <= NV_DEFAULT[1] ? '0 : SEG_UPPER;
            wel_q  <= 1'b0;
        end else if (sw_reset) begin
            v_q    <= vcfg_from_nv(nv_q);
            ev_q   <= evcfg_from_nv(nv_q);
            four_q <= ~nv_q[0];
            ext_q  <= nv_q[1] ? '0 : SEG_UPPER;
            wel_q  <= 1'b0;
        end else begin
            if (wel_set)  wel_q  <= 1'b1;
            if (wel_clr)  wel_q  <= 1'b0;
            if (four_set) four_q <= 1'b1;
            if (four_clr) four_q <= 1'b0;
            if (wr_nv)    nv_q   <= wr_word;
            if (wr_v)     v_q    <= wr_byte;
            if (wr_ev)    ev_q   <= wr_byte;
        end
    end

    assign nv        = nv_q;
    assign vcfg      = v_q;
    assign evcfg     = ev_q;
    assign wel       = wel_q;
    assign four_byte = four_q;
    assign ext_addr  = ext_q;

    assert_nv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (nv_q == $past(nv_q)));

    assert_rebuild_v_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (v_q[1:0] == 2'b11 && v_q[7:4] == $past(nv_q[15:12])));

    assert_rebuild_ev_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (ev_q[4:0] == 5'h1F && ev_q[6] == $past(nv_q[2])
                      && ev_q[7] == $past(nv_q[3])));

    assert_rebuild_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (four_q == !$past(nv_q[0])));

endmodule

// File: rtl/flash_cfg_ctrl.sv
module flash_cfg_ctrl
    import flash_cfg_pkg::*;
#(
    parameter logic [15:0] NV_DEFAULT = 16'h8FFF,
    parameter int          EXT_W      = 8,
    parameter int          UPPER_SEG  = 3,
    parameter int          CNT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              dat_valid,
    input  logic [7:0]        dat_byte,
    output logic              dout_valid,
    output logic [7:0]        dout,
    output logic              wel,
    output logic              rst_armed,
    output logic              four_byte,
    output logic [EXT_W-1:0]  ext_addr,
    output logic [7:0]        vol_cfg,
    output logic [7:0]        evol_cfg,
    output logic              addr_clr
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    seq_state_t        state_q, state_d;
    logic [7:0]        op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [7:0]        lo_q;
    logic              dout_valid_q, addr_clr_q;
    logic [7:0]        dout_q, rd_byte;
    logic [NV_W-1:0]   nv;
    logic              accept_cmd, accept_dat, commit, last_byte;
    logic              cmd_is_wr, cmd_is_rd, sw_reset;
    logic              wr_nv, wr_v, wr_ev;

    assign accept_cmd = (state_q == ST_IDLE) && cmd_valid && !cs_n;
    assign accept_dat = dat_valid && !cs_n;
    assign cmd_is_wr  = (cmd_byte == OP_NV_WR) || (cmd_byte == OP_V_WR) || (cmd_byte == OP_EV_WR);
    assign cmd_is_rd  = (cmd_byte == OP_NV_RD) || (cmd_byte == OP_V_RD) || (cmd_byte == OP_EV_RD);
    assign last_byte  = (op_q == OP_NV_WR) ? (cnt_q == CNT_W'(1)) : (cnt_q == '0);
    assign commit     = (state_q == ST_COLLECT) && accept_dat && last_byte;
    assign wr_nv      = commit && (op_q == OP_NV_WR);
    assign wr_v       = commit && (op_q == OP_V_WR);
    assign wr_ev      = commit && (op_q == OP_EV_WR);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_is_wr && wel)
                            state_d = ST_COLLECT;
                        else if (cmd_is_rd)
                            state_d = ST_READ;
                        else
                            state_d = ST_DRAIN;
                    end
                end
                ST_COLLECT: if (commit) state_d = ST_DRAIN;
                ST_READ:    state_d = ST_READ;
                ST_DRAIN:   state_d = ST_DRAIN;
            endcase
        end
    end

    // State register and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            cnt_q   <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (cs_n) begin
                cnt_q <= '0;
            end else if (accept_cmd) begin
                op_q  <= cmd_byte;
                cnt_q <= '0;
            end else if (accept_dat && (state_q == ST_COLLECT || state_q == ST_READ)) begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                if (state_q == ST_COLLECT && cnt_q == '0) lo_q <= dat_byte;
            end
        end
    end

    // Read-back byte selection
    always_comb begin
        rd_byte = '0;
        case (op_q)
            OP_NV_RD: begin
                if (cnt_q == '0)              rd_byte = nv[7:0];
                else if (cnt_q == CNT_W'(1))  rd_byte = nv[15:8];
            end
            OP_V_RD:  if (cnt_q == '0) rd_byte = vol_cfg;
            OP_EV_RD: if (cnt_q == '0) rd_byte = evol_cfg;
            default:  rd_byte = '0;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_valid_q <= 1'b0;
            dout_q       <= '0;
            addr_clr_q   <= 1'b0;
        end else begin
            dout_valid_q <= (state_q == ST_READ) && accept_dat;
            dout_q       <= ((state_q == ST_READ) && accept_dat) ? rd_byte : '0;
            addr_clr_q   <= sw_reset;
        end
    end

    assign dout_valid = dout_valid_q;
    assign dout       = dout_q;
    assign addr_clr   = addr_clr_q;

    flash_rst_arm u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_fire  (accept_cmd),
        .op_code  (cmd_byte),
        .armed    (rst_armed),
        .sw_reset (sw_reset)
    );

    flash_cfg_regs #(
        .NV_DEFAULT (NV_DEFAULT),
        .EXT_W      (EXT_W),
        .UPPER_SEG  (UPPER_SEG)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_reset  (sw_reset),
        .wel_set   (accept_cmd && cmd_byte == OP_WEL_SET),
        .wel_clr   (accept_cmd && cmd_byte == OP_WEL_CLR),
        .four_set  (accept_cmd && cmd_byte == OP_ADDR4_ON),
        .four_clr  (accept_cmd && cmd_byte == OP_ADDR4_OFF),
        .wr_nv     (wr_nv),
        .wr_v      (wr_v),
        .wr_ev     (wr_ev),
        .wr_word   ({dat_byte, lo_q}),
        .wr_byte   (dat_byte),
        .nv        (nv),
        .vcfg      (vol_cfg),
        .evcfg     (evol_cfg),
        .wel       (wel),
        .four_byte (four_byte),
        .ext_addr  (ext_addr)
    );

    assert_wel_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_nv || wr_v || wr_ev) |-> wel);

    assert_idle_on_deselect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state_q == ST_IDLE));

    assert_tail_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid_q && $past(cnt_q) > CNT_W'(1)) |-> (dout_q == '0));

    assert_clr_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_clr_q |-> (!wel && !rst_armed));

    assert_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_clr_q |=> !addr_clr_q);

endmodule

// File: tb/flash_cfg_ctrl_tb.sv
module flash_cfg_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       dat_valid = 1'b0;
    logic [7:0] dat_byte = '0;
    logic       dout_valid, wel, rst_armed, four_byte, addr_clr;
    logic [7:0] dout, ext_addr, vol_cfg, evol_cfg;

    int checks = 0;
    int fails  = 0;
    int clr_cnt = 0;
    logic [7:0] exp_q[$];

    // Reference model, from the requirements
    logic [15:0] m_nv;
    logic [7:0]  m_v, m_ev, m_ext;
    logic        m_wel, m_armed, m_four;

    always #5 clk = ~clk;

    flash_cfg_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .dat_valid(dat_valid), .dat_byte(dat_byte),
        .dout_valid(dout_valid), .dout(dout),
        .wel(wel), .rst_armed(rst_armed), .four_byte(four_byte),
        .ext_addr(ext_addr), .vol_cfg(vol_cfg), .evol_cfg(evol_cfg),
        .addr_clr(addr_clr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_rebuild();
        m_v = 8'h03;
        m_v[3] = (m_nv[11:9] != 3'b111);
        m_v[7:4] = m_nv[15:12];
        m_ev = 8'h1F;
        m_ev[6] = m_nv[2];
        m_ev[7] = m_nv[3];
        m_four = !m_nv[0];
        m_ext = m_nv[1] ? 8'h00 : 8'h03;
        m_wel = 1'b0;
        m_armed = 1'b0;
    endfunction

    function automatic logic [7:0] model_byte(input logic [7:0] op, input int idx);
        if (op == 8'hB5) return (idx == 0) ? m_nv[7:0] : (idx == 1) ? m_nv[15:8] : 8'h00;
        if (op == 8'h85) return (idx == 0) ? m_v : 8'h00;
        return (idx == 0) ? m_ev : 8'h00;
    endfunction

    task automatic check_state(input string req);
        chk({req, " vol_cfg"},   vol_cfg,   m_v);
        chk({req, " evol_cfg"},  evol_cfg,  m_ev);
        chk({req, " wel"},       wel,       m_wel);
        chk({req, " rst_armed"}, rst_armed, m_armed);
        chk({req, " four_byte"}, four_byte, m_four);
        chk({req, " ext_addr"},  ext_addr,  m_ext);
    endtask

    // One-opcode frame
    task automatic do_cmd(input logic [7:0] c);
        cs_n = 1'b0; cmd_valid = 1'b1; cmd_byte = c;
        @(negedge clk);
        cmd_valid = 1'b0; cs_n = 1'b1;
        @(negedge clk);
    endtask

    // Read frame: driver side of the scoreboard
    task automatic rd(input logic [7:0] c, input int n);
        cs_n = 1'b0; cmd_valid = 1'b1; cmd_byte = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            dat_valid = 1'b1; dat_byte = 8'hA5;
            exp_q.push_back(model_byte(c, i));
            @(negedge clk);
        end
        dat_valid = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        chk("R2 scoreboard drained", exp_q.size(), 0);
    endtask

    // Write frame; cut_last raises cs_n together with the final byte
    task automatic wr(input logic [7:0] c, input int n, input logic [7:0] b0,
                      input logic [7:0] b1, input bit cut_last);
        cs_n = 1'b0; cmd_valid = 1'b1; cmd_byte = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            dat_valid = 1'b1; dat_byte = (i == 0) ? b0 : b1;
            if (cut_last && i == n - 1) cs_n = 1'b1;
            @(negedge clk);
        end
        dat_valid = 1'b0; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_nv = 16'h8FFF;
        model_rebuild();
        @(negedge clk);
    endtask

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && dout_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected dout_valid", 1, 0);
            end else begin
                chk("R2 read-back byte", dout, exp_q.pop_front());
            end
        end
    end

    always @(posedge clk) if (rst_n && addr_clr) clr_cnt++;

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int clr_before;
        hw_reset();
        // R1: power-on values
        check_state("R1");
        chk("R1 vol_cfg value", vol_cfg, 8'h83);
        chk("R1 evol_cfg value", evol_cfg, 8'hDF);
        rd(8'hB5, 3);                 // R2 / R1: FF 8F 00
        rd(8'h85, 2);                 // R2
        rd(8'h65, 2);                 // R2

        // R3: writes ignored without write-enable
        wr(8'h81, 1, 8'h5A, 8'h00, 1'b0);
        wr(8'hB1, 2, 8'h11, 8'h22, 1'b0);
        check_state("R3 gated");
        rd(8'hB5, 2);

        // R5: set write-enable
        do_cmd(8'h06); m_wel = 1'b1;
        check_state("R5 set");

        // R3: accepted writes
        wr(8'h81, 1, 8'h5A, 8'h00, 1'b0); m_v = 8'h5A;
        wr(8'h61, 1, 8'h12, 8'h00, 1'b0); m_ev = 8'h12;
        wr(8'hB1, 2, 8'h50, 8'h2A, 1'b0); m_nv = 16'h2A50;
        check_state("R3 written");
        rd(8'hB5, 2);
        rd(8'h85, 1);
        rd(8'h65, 1);

        // R4: frames cut short, including deselect on the final byte
        wr(8'hB1, 1, 8'h77, 8'h00, 1'b0);
        wr(8'hB1, 2, 8'h77, 8'h66, 1'b1);
        wr(8'h81, 1, 8'hC3, 8'h00, 1'b1);
        wr(8'h61, 1, 8'hC3, 8'h00, 1'b1);
        check_state("R4 cut");
        rd(8'hB5, 2);

        // R5: clear write-enable
        do_cmd(8'h04); m_wel = 1'b0;
        check_state("R5 clear");

        // R7: reset opcode while unarmed
        clr_before = clr_cnt;
        do_cmd(8'h99);
        check_state("R7 unarmed");
        chk("R7 no addr_clr", clr_cnt, clr_before);

        // R6: arm, then another opcode disarms
        do_cmd(8'h66); m_armed = 1'b1;
        check_state("R6 armed");
        do_cmd(8'h06); m_armed = 1'b0; m_wel = 1'b1;
        check_state("R6 disarmed");
        do_cmd(8'h99);
        check_state("R7 after disarm");
        chk("R7 no addr_clr after disarm", clr_cnt, clr_before);

        // R8 / R9 / R10 / R11: valid software reset with nv = 0x2A50
        do_cmd(8'h66);
        do_cmd(8'h99); model_rebuild();
        check_state("R8 R9 R10 R11 sw reset");
        chk("R9 vol_cfg 0x2B", vol_cfg, 8'h2B);
        chk("R10 evol_cfg 0x1F", evol_cfg, 8'h1F);
        chk("R11 ext_addr upper", ext_addr, 8'h03);
        chk("R8 addr_clr one pulse", clr_cnt, clr_before + 1);
        chk("R8 addr_clr low after", addr_clr, 1'b0);
        rd(8'hB5, 2);                 // R8: nv retained

        // R11: explicit address-mode opcodes
        do_cmd(8'hE9); m_four = 1'b0;
        check_state("R11 exit 4-byte");
        do_cmd(8'hB7); m_four = 1'b1;
        check_state("R11 enter 4-byte");

        // R9 / R10 / R11: second pattern, nv[11:9] all ones, repeated arm
        do_cmd(8'h06); m_wel = 1'b1;
        wr(8'hB1, 2, 8'h0E, 8'h7E, 1'b0); m_nv = 16'h7E0E;
        do_cmd(8'h66);
        do_cmd(8'h66); m_armed = 1'b1;
        check_state("R6 double arm");
        do_cmd(8'h99); model_rebuild();
        check_state("R9 R10 R11 pattern 2");
        chk("R9 vol_cfg 0x73", vol_cfg, 8'h73);
        chk("R10 evol_cfg 0xDF", evol_cfg, 8'hDF);
        chk("R11 ext_addr low", ext_addr, 8'h00);
        chk("R8 second pulse", clr_cnt, clr_before + 2);

        // R1: hardware reset restores persistent default
        hw_reset();
        check_state("R1 second reset");
        rd(8'hB5, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule